// File: doc/BRIEF.md
# Synchronous Flow-Through Burst SRAM

This block is a synthesizable model of a single-port synchronous SRAM with a shared data bus that needs no idle cycles when traffic turns from writes to reads. Control, address and byte strobes are sampled on the rising clock edge, and an active-low clock enable qualifies every edge. An access starts when the load/advance control is low and all three chip selects are active. Each write beat takes its data on the clock edge after its address. Each read beat drives the addressed word combinationally in the cycle after its address edge (flow-through). This allows any mix of reads and writes to run on consecutive edges.

A loaded access can be extended into a burst of up to four beats by holding load/advance high. A 2-bit counter then steps the two lowest address bits. The start offset can be added to the beat count (linear order) or XORed with it (interleaved order). The read/write type and the burst order are fixed when the access is loaded. Each word is split into four lanes of nine bits (eight data bits plus parity). Each lane has its own write strobe. The bidirectional bus is modelled as separate input, output and drive-enable signals.

Top module: `sync_burst_sram`

## Requirements
- R1: On a clock edge where `cen_n` is high, nothing changes. No write takes place, the burst position is unchanged, the access type is unchanged, and a read being presented keeps showing the same word.
- R2: An access is loaded on an edge where `cen_n`=0, `adv_ld_n`=0, `ce1_n`=0, `ce2`=1 and `ce3_n`=0. `we_n`=1 at that edge makes it a read, and `we_n`=0 makes it a write.
- R3: After an edge that issues a read beat, `dq_out` carries the stored word at the beat's address during the following cycle. `dq_oe` is high in that cycle exactly while `oe_n` is low. Whenever `dq_oe` is low, `dq_out` is zero.
- R4: The data for a write beat is taken from `dq_in` on the next edge with `cen_n`=0. That same edge may load or advance another access. A read loaded on it returns the word just written.
- R5: Each word has four lanes. Lane i is bits [9i+8:9i]. Lane i is written only if `bw_n[i]` was 0 on the edge that issued the beat. Lanes with `bw_n[i]`=1 keep their earlier contents.
- R6: While a write beat is waiting for its data, `dq_oe` stays low whatever the level of `oe_n`.
- R7: An edge with `cen_n`=0 and `adv_ld_n`=1 during an active access moves to the next beat. This happens whatever the levels of the chip selects and `we_n`. The beat count wraps to the start offset after four beats.
- R8: The burst order is taken from `mode` when the access is loaded. With `mode`=0, the low address bits of beat n are (start+n) mod 4. With `mode`=1, they are start XOR n. The upper address bits stay as loaded.
- R9: Every beat of a burst keeps the read/write type loaded at its start. The level of `we_n` on advance edges has no effect.
- R10: An edge with `cen_n`=0, `adv_ld_n`=0 and any chip select inactive deselects the device, and `dq_oe` goes low in the following cycle. Advance edges while deselected do not start or resume an access.
- R11: While `rst_n` is low, and after it is released, the device is deselected and `dq_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cen_n | input | 1 | Active-low clock enable |
| ce1_n | input | 1 | Active-low chip select |
| ce2 | input | 1 | Active-high chip select |
| ce3_n | input | 1 | Active-low chip select |
| adv_ld_n | input | 1 | Low: load a new access; high: advance the burst |
| we_n | input | 1 | Access type at load: 0 write, 1 read |
| bw_n | input | LANES | Active-low per-lane write strobes |
| mode | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| oe_n | input | 1 | Asynchronous active-low output enable |
| addr | input | ADDR_W | Word address |
| dq_in | input | LANES*LANE_W | Data bus as seen entering the device |
| dq_out | output | LANES*LANE_W | Data bus as driven by the device |
| dq_oe | output | 1 | Device drives the data bus |

## Verification
Two situations are the hardest to reach from the ports. The first is an edge that carries the data of one write beat and the address of the next operation together. The second is a stalled edge with `cen_n` high that falls inside a burst or while a write is pending. The stimulus places write loads, burst advances and reads on consecutive edges, so each data edge is also a command edge. It inserts stalls carrying decoy data mid-burst and between a write's address and data edges. It also toggles `we_n` and the chip selects during advance edges. A behavioural reference model, with a sparse memory and its own beat arithmetic, predicts the bus drive and data for every cycle.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

  localparam int unsigned LANES  = 4;
  localparam int unsigned LANE_W = 9;

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } burst_order_e;

  // Low address bits of beat 'cnt' for a burst starting at 'start'.
  function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                             input logic [1:0] cnt,
                                             input burst_order_e ord);
    logic [1:0] r;
    if (ord == ORDER_INTERLEAVE) r = start ^ cnt;
    else                         r = start + cnt;
    return r;
  endfunction

endpackage

// File: rtl/sbs_burst_ctrl.sv
module sbs_burst_ctrl
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NLANE  = LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              sel,
  input  logic              adv_ld_n,
  input  logic              we_n,
  input  logic [NLANE-1:0]  bw_n,
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  output logic              acc_active,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [NLANE-1:0]  acc_bw_n
);

  localparam int unsigned HI_W = ADDR_W - 2;

  logic              act_q,   act_d;
  logic              wr_q,    wr_d;
  logic [HI_W-1:0]   base_q,  base_d;
  logic [1:0]        start_q, start_d;
  logic [1:0]        cnt_q,   cnt_d;
  burst_order_e      ord_q,   ord_d;
  logic [NLANE-1:0]  bw_q,    bw_d;

  always_comb begin
    act_d   = act_q;
    wr_d    = wr_q;
    base_d  = base_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    ord_d   = ord_q;
    bw_d    = bw_q;
    if (!cen_n) begin
      bw_d = bw_n;
      if (!adv_ld_n) begin
        if (sel) begin
          act_d   = 1'b1;
          wr_d    = !we_n;
          base_d  = addr[ADDR_W-1:2];
          start_d = addr[1:0];
          cnt_d   = 2'd0;
          ord_d   = burst_order_e'(mode);
        end else begin
          act_d = 1'b0;
        end
      end else if (act_q) begin
        cnt_d = cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      start_q <= 2'd0;
      cnt_q   <= 2'd0;
      ord_q   <= ORDER_LINEAR;
      bw_q    <= '1;
    end else if (!cen_n) begin
      act_q   <= act_d;
      wr_q    <= wr_d;
      base_q  <= base_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
      ord_q   <= ord_d;
      bw_q    <= bw_d;
    end
  end

  assign acc_active = act_q;
  assign acc_write  = wr_q;
  assign acc_addr   = {base_q, beat_offset(start_q, cnt_q, ord_q)};
  assign acc_bw_n   = bw_q;

  // R1: a disabled edge leaves all control state untouched
  a_r1_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> $stable({act_q, wr_q, base_q, start_q, cnt_q, ord_q, bw_q}));

  // R7: an advance edge during an access steps the beat count with wrap
  a_r7_beat_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n && act_q) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

  // R9: advance edges keep the access type
  a_r9_type_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n) |=> (wr_q == $past(wr_q)));

  // R10: advance edges never wake a deselected device
  a_r10_idle_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && adv_ld_n && !act_q) |=> !act_q);

endmodule

// File: rtl/sbs_lane_array.sv
module sbs_lane_array
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NLANE  = LANES,
  parameter int unsigned LW     = LANE_W
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [NLANE-1:0]    wr_mask_n,
  input  logic [ADDR_W-1:0]   word_addr,
  input  logic [NLANE*LW-1:0] wr_data,
  output logic [NLANE*LW-1:0] rd_data
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [LW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && !wr_mask_n[g]) begin
        store[word_addr] <= wr_data[g*LW +: LW];
      end
    end

    assign rd_data[g*LW +: LW] = store[word_addr];
  end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned NLANE  = LANES,
  parameter int unsigned LW     = LANE_W,
  localparam int unsigned DQ_W  = NLANE * LW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              adv_ld_n,
  input  logic              we_n,
  input  logic [NLANE-1:0]  bw_n,
  input  logic              mode,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DQ_W-1:0]   dq_in,
  output logic [DQ_W-1:0]   dq_out,
  output logic              dq_oe
);

  logic              sel;
  logic              acc_active;
  logic              acc_write;
  logic [ADDR_W-1:0] acc_addr;
  logic [NLANE-1:0]  acc_bw_n;
  logic              wr_fire;
  logic [DQ_W-1:0]   rd_word;

  assign sel = !ce1_n && ce2 && !ce3_n;

  sbs_burst_ctrl #(.ADDR_W(ADDR_W), .NLANE(NLANE)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cen_n      (cen_n),
    .sel        (sel),
    .adv_ld_n   (adv_ld_n),
    .we_n       (we_n),
    .bw_n       (bw_n),
    .mode       (mode),
    .addr       (addr),
    .acc_active (acc_active),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .acc_bw_n   (acc_bw_n)
  );

  // A pending write beat completes on the next enabled edge.
  assign wr_fire = !cen_n && acc_active && acc_write;

  sbs_lane_array #(.ADDR_W(ADDR_W), .NLANE(NLANE), .LW(LW)) u_array (
    .clk       (clk),
    .wr_en     (wr_fire),
    .wr_mask_n (acc_bw_n),
    .word_addr (acc_addr),
    .wr_data   (dq_in),
    .rd_data   (rd_word)
  );

  always_comb begin
    dq_oe  = acc_active && !acc_write && !oe_n;
    dq_out = dq_oe ? rd_word : '0;
  end

  // R10: a deselect edge releases the bus in the next cycle
  a_r10_deselect_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && !sel) |=> !dq_oe);

  // R6: bus stays released while a loaded write awaits its data
  a_r6_write_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !adv_ld_n && sel && !we_n) |=> !dq_oe);

endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;

  localparam int PERIOD = 10;
  localparam int AW     = 6;
  localparam int DW     = 36;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cen_n, ce1_n, ce2, ce3_n, adv_ld_n, we_n, mode, oe_n;
  logic [3:0]    bw_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R11";
  bit    done = 0;

  sync_burst_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .adv_ld_n(adv_ld_n), .we_n(we_n), .bw_n(bw_n),
    .mode(mode), .oe_n(oe_n), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #(PERIOD/2) clk = ~clk;

  // Behavioural reference model
  logic [DW-1:0] ref_mem [int];
  bit            m_act, m_wr, m_ord;
  int            m_base, m_start, m_cnt;
  logic [3:0]    m_bw;

  function automatic int beat_addr();
    int lo;
    lo = m_ord ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
    return m_base * 4 + lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_cnt = 0; m_bw = 4'hF;
    end else if (!cen_n) begin
      if (m_act && m_wr) begin
        logic [DW-1:0] old;
        int a;
        a = beat_addr();
        old = ref_mem.exists(a) ? ref_mem[a] : '0;
        for (int i = 0; i < 4; i++)
          if (!m_bw[i]) old[i*9 +: 9] = dq_in[i*9 +: 9];
        ref_mem[a] = old;
      end
      m_bw = bw_n;
      if (!adv_ld_n) begin
        if (!ce1_n && ce2 && !ce3_n) begin
          m_act = 1; m_wr = !we_n; m_base = int'(addr) / 4;
          m_start = int'(addr) % 4; m_cnt = 0; m_ord = mode;
        end else begin
          m_act = 0;
        end
      end else if (m_act) begin
        m_cnt = (m_cnt + 1) % 4;
      end
    end
  end

  // Per-cycle comparison away from the clock edge
  always @(negedge clk) begin
    if (!done) begin
      bit exp_oe;
      exp_oe = m_act && !m_wr && !oe_n;
      checks++;
      if (dq_oe !== exp_oe) begin
        errors++;
        $display("FAIL %s: dq_oe actual=%b expected=%b at %0t", cur_req, dq_oe, exp_oe, $time);
      end
      if (exp_oe && ref_mem.exists(beat_addr())) begin
        checks++;
        if (dq_out !== ref_mem[beat_addr()]) begin
          errors++;
          $display("FAIL %s: dq_out actual=%h expected=%h addr=%0d", cur_req, dq_out,
                   ref_mem[beat_addr()], beat_addr());
        end
      end else if (!exp_oe) begin
        checks++;
        if (dq_out !== '0) begin
          errors++;
          $display("FAIL %s: idle dq_out actual=%h expected=0", cur_req, dq_out);
        end
      end
    end
  end

  function automatic logic [DW-1:0] pat(int a, int k);
    return DW'(36'h9_5A3C_1E87 ^ (36'(a) * 36'h1_0203_0405) ^ (36'(k) << 20));
  endfunction

  // sc: 0 all selects active, 1/2/3 drop ce1_n/ce2/ce3_n
  task automatic step(input bit c_n, input int sc, input bit adv_n, input bit w_n,
                      input logic [3:0] b_n, input int a, input bit md,
                      input logic [DW-1:0] d, input bit o_n, input string r);
    @(posedge clk);
    #2;
    cen_n = c_n; ce1_n = (sc == 1); ce2 = (sc != 2); ce3_n = (sc == 3);
    adv_ld_n = adv_n; we_n = w_n; bw_n = b_n; addr = AW'(a); mode = md;
    dq_in = d; oe_n = o_n; cur_req = r;
  endtask

  localparam logic [DW-1:0] JUNK = 36'hF_0F0F_0F0F;

  initial begin
    rst_n = 0; cen_n = 0; ce1_n = 1; ce2 = 0; ce3_n = 1; adv_ld_n = 0;
    we_n = 1; bw_n = 4'hF; addr = '0; mode = 0; dq_in = JUNK; oe_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    // R11: idle after reset with oe_n low
    step(0, 0, 1, 1, 4'hF, 0, 0, JUNK, 0, "R11");
    step(0, 0, 1, 1, 4'hF, 0, 0, JUNK, 0, "R11");
    // R2 R4: back-to-back single writes then reads
    step(0, 0, 0, 0, 4'h0, 8,  0, JUNK,     0, "R2");
    step(0, 0, 0, 0, 4'h0, 9,  0, pat(8,1), 0, "R4");
    step(0, 0, 0, 0, 4'h0, 10, 0, pat(9,1), 0, "R4");
    step(0, 0, 0, 1, 4'hF, 10, 0, pat(10,1),0, "R4");
    step(0, 0, 0, 1, 4'hF, 8,  0, JUNK,     0, "R3");
    step(0, 0, 0, 0, 4'h0, 11, 0, JUNK,     1, "R3");
    step(0, 0, 0, 1, 4'hF, 9,  0, pat(11,1),0, "R4");
    step(0, 0, 0, 1, 4'hF, 11, 1, JUNK,     1, "R3");
    // R5: full write then masked write lanes 0 and 2
    step(0, 0, 0, 0, 4'h0, 12, 0, JUNK,     0, "R5");
    step(0, 0, 0, 0, 4'b1010, 12, 0, pat(12,1), 0, "R5");
    step(0, 0, 0, 1, 4'hF, 12, 0, pat(12,2), 0, "R5");
    step(0, 0, 0, 0, 4'b0111, 13, 0, JUNK,   0, "R6");
    step(0, 0, 0, 1, 4'hF, 13, 0, pat(13,1), 0, "R5");
    // R7 R8 R9: linear write burst from 17, we_n high on advances
    step(0, 0, 0, 0, 4'h0, 17, 0, JUNK,      0, "R7");
    step(0, 0, 1, 1, 4'h0, 0,  1, pat(17,3), 0, "R9");
    step(0, 0, 1, 1, 4'h0, 0,  1, pat(18,3), 0, "R9");
    step(0, 2, 1, 1, 4'h0, 0,  1, pat(19,3), 0, "R7");
    step(0, 0, 0, 1, 4'hF, 17, 0, pat(16,3), 0, "R8");
    step(0, 0, 1, 0, 4'h0, 0,  1, JUNK,      0, "R9");
    step(0, 0, 1, 0, 4'h0, 0,  1, JUNK,      0, "R9");
    step(0, 0, 1, 0, 4'h0, 0,  1, JUNK,      0, "R8");
    step(0, 0, 1, 1, 4'hF, 0,  0, JUNK,      0, "R7");
    // R8: interleaved write burst from 22, then both orders read
    step(0, 0, 0, 0, 4'h0, 22, 1, JUNK,      0, "R8");
    step(0, 0, 1, 0, 4'h0, 0,  0, pat(22,4), 0, "R8");
    step(0, 0, 1, 0, 4'h0, 0,  0, pat(23,4), 0, "R8");
    step(0, 0, 1, 0, 4'h0, 0,  0, pat(20,4), 0, "R8");
    step(0, 0, 0, 1, 4'hF, 22, 1, pat(21,4), 0, "R8");
    step(0, 0, 1, 1, 4'hF, 0,  0, JUNK, 0, "R8");
    step(0, 0, 1, 1, 4'hF, 0,  0, JUNK, 0, "R8");
    step(0, 0, 1, 1, 4'hF, 0,  0, JUNK, 0, "R8");
    step(0, 0, 0, 1, 4'hF, 21, 0, JUNK, 0, "R8");
    step(0, 0, 1, 1, 4'hF, 0,  1, JUNK, 0, "R8");
    step(0, 0, 1, 1, 4'hF, 0,  1, JUNK, 0, "R8");
    // R1: stalls inside a read burst and between write address and data
    step(1, 0, 0, 0, 4'h0, 40, 1, JUNK, 0, "R1");
    step(1, 1, 1, 0, 4'h0, 41, 1, JUNK, 0, "R1");
    step(0, 0, 1, 1, 4'hF, 0,  0, JUNK, 0, "R1");
    step(0, 0, 0, 0, 4'h0, 24, 0, JUNK, 0, "R1");
    step(1, 0, 0, 1, 4'hF, 25, 0, JUNK, 0, "R1");
    step(1, 0, 1, 1, 4'hF, 25, 0, JUNK, 1, "R6");
    step(0, 0, 0, 1, 4'hF, 24, 0, pat(24,5), 0, "R1");
    step(0, 0, 1, 1, 4'hF, 0,  0, JUNK, 0, "R1");
    // R10: deselect by each select, advances ignored, then reload
    step(0, 0, 0, 1, 4'hF, 8,  0, JUNK, 0, "R10");
    step(0, 2, 0, 1, 4'hF, 9,  0, JUNK, 0, "R10");
    step(0, 0, 1, 1, 4'hF, 9,  0, JUNK, 0, "R10");
    step(0, 0, 1, 0, 4'h0, 9,  0, JUNK, 0, "R10");
    step(0, 0, 0, 1, 4'hF, 10, 0, JUNK, 0, "R10");
    step(0, 1, 0, 1, 4'hF, 10, 0, JUNK, 0, "R10");
    step(0, 0, 0, 1, 4'hF, 11, 0, JUNK, 0, "R10");
    step(0, 3, 0, 0, 4'h0, 11, 0, JUNK, 0, "R10");
    step(0, 0, 1, 1, 4'hF, 11, 0, pat(0,9), 0, "R10");
    step(0, 0, 0, 1, 4'hF, 9,  0, JUNK, 0, "R2");
    step(0, 0, 0, 1, 4'hF, 11, 0, JUNK, 0, "R2");
    // R11: reset in the middle of a read
    @(posedge clk); #2 rst_n = 0; cur_req = "R11";
    @(posedge clk); #2 rst_n = 1;
    step(0, 0, 1, 1, 4'hF, 0, 0, JUNK, 0, "R11");
    @(posedge clk); @(negedge clk); #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule